// File: doc/BRIEF.md
# Digital CVSD Codec Core

This block is a fully digital continuously variable slope delta (CVSD) codec. The encoder compares a held signed PCM sample with its own running estimate once per bit period and sends one bit. The decoder takes one received bit per bit period and rebuilds the same estimate, which is its PCM output. Both sides use the same slope engine. It has a leaky integrator that saturates at the signed limits, and a step size that grows while the recent bits agree and shrinks otherwise. An input selects whether a run of three or of four equal bits counts as agreement.

Each side has its own bit-period source. It is either a divider of the system clock or an external clock that is synchronised and edge-detected. Each side also has its own active-low idle input, which replaces the bit stream with a strict 0,1,0,1 pattern. A power-save input holds the whole core in a cleared, quiet state. The encoder bit has a separate enable output in place of a three-state pad.

Top module: `cvsd_codec`

## Requirements
- R1: While `pwrOn` is low, or after `rstN` has been low, both estimates read 0, `encBit` is 0, the step sizes are at `STEP_MIN`, the bit histories are all zeros and no `encTick` or `decTick` pulse occurs.
- R2: On each encoder tick the new bit is 1 when the latched sample is greater than or equal to the encoder estimate, and 0 otherwise. The sample is latched from `sampleIn` on a clock edge where `sampleStb` is high. The bit appears on `encBit` one clock later.
- R3: On each tick the step size rises by `STEP_INC`, capped at `STEP_MAX`, when the new bit equals the previous two bits (`algo3` = 1) or the previous three bits (`algo3` = 0). Otherwise the step loses `step >> STEP_LEAK`, floored at `STEP_MIN`.
- R4: On each tick the estimate becomes `est - (est >>> EST_LEAK)`. The new step size is then added for a 1 bit or subtracted for a 0 bit.
- R5: The estimate saturates at +2^(W-1)-1 and -2^(W-1). A full-scale positive input drives it to and holds it at the positive limit.
- R6: While `encIdleN` is low, the encoder bits are 0,1,0,1,… starting with 0 at the first idle tick, whatever the sample.
- R7: While `decIdleN` is low, the decoder ignores `decBitIn` and uses a 0,1,0,1,… pattern. After 600 bit periods `decSample` lies within 8·`STEP_MIN` of zero.
- R8: The decoder update is the same as the encoder update. When the encoder bit is looped back into the decoder, `decSample` equals the encoder estimate after every decoded bit.
- R9: `encBitEn` is high exactly when `dataEn` and `pwrOn` are both high. The encoder keeps running while it is low.
- R10: With `encClkInt`/`decClkInt` high, the side ticks every `CLK_DIV` system clocks.
- R11: With the internal select low, the side ticks once per rising edge of its external clock, two clocks after the edge is sampled. The tick spacing follows the external period.
- R12: Estimates change only on a tick of their own side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (bit-rate reference) |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrOn | input | 1 | 1 = run, 0 = quiescent and cleared |
| algo3 | input | 1 | 1 = three-bit run, 0 = four-bit run |
| dataEn | input | 1 | Encoder output enable request |
| encClkInt | input | 1 | Encoder bit clock: 1 = internal divider, 0 = external |
| encExtClk | input | 1 | External encoder bit clock |
| decClkInt | input | 1 | Decoder bit clock: 1 = internal divider, 0 = external |
| decExtClk | input | 1 | External decoder bit clock |
| sampleIn | input | W | Signed PCM sample to encode |
| sampleStb | input | 1 | Latches `sampleIn` |
| encIdleN | input | 1 | Active-low encoder idle force |
| encBit | output | 1 | Encoded bit |
| encBitEn | output | 1 | Encoded bit is driven |
| encTick | output | 1 | One-clock pulse per encoder bit period |
| encEst | output | W | Encoder estimate |
| decBitIn | input | 1 | Received bit |
| decIdleN | input | 1 | Active-low decoder idle force |
| decTick | output | 1 | One-clock pulse per decoder bit period |
| decSample | output | W | Reconstructed signed PCM sample |

## Verification
The assertions assume that both external bit clocks are synchronous to `clk` and that each stays high and low for at least one clock. They also assume `CLK_DIV` is at least two, so that every tick is a single-cycle pulse, and that `pwrOn` low lasts at least two clocks when it is checked for quiet. The stimulus changes samples, idle inputs, `algo3` and `dataEn` only in the gap between ticks. It drives the encoder's external clock with a 4-high/6-low pattern on `clk`. It feeds the decoder's external clock from `encTick`, so every decoded bit is the encoder bit that was just registered.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

  // Strobes from the control block to the datapath
  typedef struct packed {
    logic clear;        // power-save clear
    logic encTick;      // encoder bit period
    logic decTick;      // decoder bit period
    logic encForce;     // encoder idle force active
    logic encForceBit;  // encoder idle pattern bit
    logic decForce;     // decoder idle force active
    logic decForceBit;  // decoder idle pattern bit
    logic runLen3;      // 1: three-bit run, 0: four-bit run
  } cvsdStrobe_t;

endpackage

// File: rtl/cvsd_tick_gen.sv
module cvsd_tick_gen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic useInt,
  input  logic extClk,
  output logic tick
);

  localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;
  logic sync1, sync2, prevLvl;
  logic intTick, extTick;

  assign intTick = (cnt == CNT_LAST);
  assign extTick = sync2 & ~prevLvl;
  assign tick    = ~clear & (useInt ? intTick : extTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      prevLvl <= 1'b0;
    end else if (clear) begin
      cnt     <= '0;
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      prevLvl <= 1'b0;
    end else begin
      cnt     <= intTick ? '0 : cnt + 1'b1;
      sync1   <= extClk;
      sync2   <= sync1;
      prevLvl <= sync2;
    end
  end

  // R10, R11: a bit period is marked by a single-cycle pulse
  assert_tick_pulse_R10 : assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

endmodule

// File: rtl/cvsd_ctrl.sv
module cvsd_ctrl
  import cvsd_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrOn,
  input  logic        algo3,
  input  logic        encClkInt,
  input  logic        decClkInt,
  input  logic        encExtClk,
  input  logic        decExtClk,
  input  logic        encIdleN,
  input  logic        decIdleN,
  output cvsdStrobe_t strb
);

  localparam int SIDES = 2;

  logic             clear;
  logic [SIDES-1:0] useIntV, extV, tickV;
  logic             encPhase, decPhase;

  assign clear   = ~pwrOn;
  assign useIntV = {decClkInt, encClkInt};
  assign extV    = {decExtClk, encExtClk};

  // One bit-period source per side: index 0 encoder, 1 decoder
  generate
    for (genvar s = 0; s < SIDES; s++) begin : g_side
      cvsd_tick_gen #(.CLK_DIV(CLK_DIV)) i_tick (
        .clk    (clk),
        .rstN   (rstN),
        .clear  (clear),
        .useInt (useIntV[s]),
        .extClk (extV[s]),
        .tick   (tickV[s])
      );
    end
  endgenerate

  // Idle pattern phases: first idle bit is 0, then alternate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encPhase <= 1'b0;
      decPhase <= 1'b0;
    end else begin
      if (clear || encIdleN) encPhase <= 1'b0;
      else if (tickV[0])     encPhase <= ~encPhase;
      if (clear || decIdleN) decPhase <= 1'b0;
      else if (tickV[1])     decPhase <= ~decPhase;
    end
  end

  always_comb begin
    strb.clear       = clear;
    strb.encTick     = tickV[0];
    strb.decTick     = tickV[1];
    strb.encForce    = ~encIdleN;
    strb.encForceBit = encPhase;
    strb.decForce    = ~decIdleN;
    strb.decForceBit = decPhase;
    strb.runLen3     = algo3;
  end

endmodule

// File: rtl/cvsd_slope.sv
module cvsd_slope #(
  parameter int W         = 16,
  parameter int STEP_MIN  = 16,
  parameter int STEP_MAX  = 1024,
  parameter int STEP_INC  = 64,
  parameter int STEP_LEAK = 3,
  parameter int EST_LEAK  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clear,
  input  logic                tick,
  input  logic                bitIn,
  input  logic                runLen3,
  output logic signed [W-1:0] est
);

  localparam int XW = W + 2;
  localparam logic [W-1:0]         S_MIN  = W'(STEP_MIN);
  localparam logic [W-1:0]         S_MAX  = W'(STEP_MAX);
  localparam logic [W-1:0]         S_INC  = W'(STEP_INC);
  localparam logic signed [XW-1:0] SAT_HI = XW'((2 ** (W - 1)) - 1);
  localparam logic signed [XW-1:0] SAT_LO = XW'(-(2 ** (W - 1)));

  logic [2:0]              hist;
  logic [W-1:0]            step, stepUp, stepDn, stepNext;
  logic                    run3, runHit;
  logic signed [XW-1:0]    estX, leakX, stepX, sumX;
  logic signed [W-1:0]     estNext;

  always_comb begin
    run3   = (hist[1:0] == {bitIn, bitIn});
    runHit = runLen3 ? run3 : (run3 && (hist[2] == bitIn));

    stepUp = step + S_INC;
    stepDn = step - (step >> STEP_LEAK);
    if (runHit) stepNext = (stepUp > S_MAX) ? S_MAX : stepUp;
    else        stepNext = (stepDn < S_MIN) ? S_MIN : stepDn;

    estX  = XW'(est);
    leakX = estX - (estX >>> EST_LEAK);
    stepX = $signed({2'b00, stepNext});
    sumX  = bitIn ? (leakX + stepX) : (leakX - stepX);

    if (sumX > SAT_HI)      estNext = SAT_HI[W-1:0];
    else if (sumX < SAT_LO) estNext = SAT_LO[W-1:0];
    else                    estNext = sumX[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
      step <= S_MIN;
      est  <= '0;
    end else if (clear) begin
      hist <= '0;
      step <= S_MIN;
      est  <= '0;
    end else if (tick) begin
      hist <= {hist[1:0], bitIn};
      step <= stepNext;
      est  <= estNext;
    end
  end

  assert_step_grow_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (tick && runHit && !clear) |=> (step >= $past(step)));

  assert_step_shrink_R3 : assert property (@(posedge clk) disable iff (!rstN)
    (tick && !runHit && !clear) |=> (step <= $past(step)));

  assert_est_hold_R12 : assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !clear) |=> $stable(est));

endmodule

// File: rtl/cvsd_datapath.sv
module cvsd_datapath
  import cvsd_pkg::*;
#(
  parameter int W         = 16,
  parameter int STEP_MIN  = 16,
  parameter int STEP_MAX  = 1024,
  parameter int STEP_INC  = 64,
  parameter int STEP_LEAK = 3,
  parameter int EST_LEAK  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  cvsdStrobe_t         strb,
  input  logic signed [W-1:0] sampleIn,
  input  logic                sampleStb,
  input  logic                decBitIn,
  output logic                encBit,
  output logic signed [W-1:0] encEst,
  output logic signed [W-1:0] decEst
);

  localparam int SIDES = 2;

  logic signed [W-1:0] sampleReg;
  logic                encRaw, encNext, decNext;
  logic [SIDES-1:0]    bitV, tickV;
  logic signed [W-1:0] estV [SIDES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sampleReg <= '0;
    else if (sampleStb) sampleReg <= sampleIn;
  end

  assign encRaw  = (sampleReg >= estV[0]);
  assign encNext = strb.encForce ? strb.encForceBit : encRaw;
  assign decNext = strb.decForce ? strb.decForceBit : decBitIn;
  assign bitV    = {decNext, encNext};
  assign tickV   = {strb.decTick, strb.encTick};

  // Identical slope engines: index 0 encoder, 1 decoder
  generate
    for (genvar s = 0; s < SIDES; s++) begin : g_engine
      cvsd_slope #(
        .W(W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
        .STEP_INC(STEP_INC), .STEP_LEAK(STEP_LEAK), .EST_LEAK(EST_LEAK)
      ) i_slope (
        .clk     (clk),
        .rstN    (rstN),
        .clear   (strb.clear),
        .tick    (tickV[s]),
        .bitIn   (bitV[s]),
        .runLen3 (strb.runLen3),
        .est     (estV[s])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             encBit <= 1'b0;
    else if (strb.clear)   encBit <= 1'b0;
    else if (strb.encTick) encBit <= encNext;
  end

  assign encEst = estV[0];
  assign decEst = estV[1];

endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec
  import cvsd_pkg::*;
#(
  parameter int W         = 16,
  parameter int CLK_DIV   = 8,
  parameter int STEP_MIN  = 16,
  parameter int STEP_MAX  = 1024,
  parameter int STEP_INC  = 64,
  parameter int STEP_LEAK = 3,
  parameter int EST_LEAK  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrOn,
  input  logic                algo3,
  input  logic                dataEn,
  input  logic                encClkInt,
  input  logic                encExtClk,
  input  logic                decClkInt,
  input  logic                decExtClk,
  input  logic signed [W-1:0] sampleIn,
  input  logic                sampleStb,
  input  logic                encIdleN,
  output logic                encBit,
  output logic                encBitEn,
  output logic                encTick,
  output logic signed [W-1:0] encEst,
  input  logic                decBitIn,
  input  logic                decIdleN,
  output logic                decTick,
  output logic signed [W-1:0] decSample
);

  cvsdStrobe_t strb;

  cvsd_ctrl #(.CLK_DIV(CLK_DIV)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrOn     (pwrOn),
    .algo3     (algo3),
    .encClkInt (encClkInt),
    .decClkInt (decClkInt),
    .encExtClk (encExtClk),
    .decExtClk (decExtClk),
    .encIdleN  (encIdleN),
    .decIdleN  (decIdleN),
    .strb      (strb)
  );

  cvsd_datapath #(
    .W(W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
    .STEP_INC(STEP_INC), .STEP_LEAK(STEP_LEAK), .EST_LEAK(EST_LEAK)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sampleIn  (sampleIn),
    .sampleStb (sampleStb),
    .decBitIn  (decBitIn),
    .encBit    (encBit),
    .encEst    (encEst),
    .decEst    (decSample)
  );

  assign encBitEn = dataEn & pwrOn;
  assign encTick  = strb.encTick;
  assign decTick  = strb.decTick;

  // R1: two cycles into power-save everything is cleared and quiet
  assert_quiet_R1 : assert property (@(posedge clk) disable iff (!rstN)
    (!pwrOn ##1 !pwrOn) |-> (encEst == '0 && decSample == '0 && !encTick && !decTick));

  // R6: encoder output follows the control block's idle pattern
  assert_idle_bit_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (strb.encTick && strb.encForce) |=> (encBit == $past(strb.encForceBit)));

endmodule

// File: tb/test_cvsd_codec.sv
`timescale 1ns/1ps
module test_cvsd_codec;

  localparam int W = 16, DIV = 8, SMIN = 16, SMAX = 1024, SINC = 64;
  localparam int SLEAK = 3, ELEAK = 6;
  localparam int EMAX = 32767, EMIN = -32768;
  localparam int VEC_N = 12;
  localparam int VEC_BITS = 10;
  localparam int vecSample [VEC_N] = '{0, 12000, 12000, -9000, 300, -300,
                                       25000, -25000, 4000, 4000, -100, 0};
  localparam bit vecAlgo [VEC_N] = '{1, 1, 0, 0, 1, 0, 1, 0, 1, 0, 1, 0};

  logic clk = 1'b0;
  logic rstN, pwrOn, algo3, dataEn, encClkInt, encExtClk, decClkInt;
  logic signed [W-1:0] sampleIn;
  logic sampleStb, encIdleN, decIdleN;
  logic encBit, encBitEn, encTick, decTick;
  logic signed [W-1:0] encEst, decSample;
  logic decExtClk, decBitIn;

  assign decExtClk = encTick;  // decoder steps right after the encoder
  assign decBitIn  = encBit;   // loopback

  cvsd_codec #(.W(W), .CLK_DIV(DIV), .STEP_MIN(SMIN), .STEP_MAX(SMAX),
               .STEP_INC(SINC), .STEP_LEAK(SLEAK), .EST_LEAK(ELEAK)) i_cvsd_codec (
    .clk(clk), .rstN(rstN), .pwrOn(pwrOn), .algo3(algo3), .dataEn(dataEn),
    .encClkInt(encClkInt), .encExtClk(encExtClk), .decClkInt(decClkInt),
    .decExtClk(decExtClk), .sampleIn(sampleIn), .sampleStb(sampleStb),
    .encIdleN(encIdleN), .encBit(encBit), .encBitEn(encBitEn), .encTick(encTick),
    .encEst(encEst), .decBitIn(decBitIn), .decIdleN(decIdleN), .decTick(decTick),
    .decSample(decSample));

  always #2.5 clk = ~clk;

  int nRun = 0, nFail = 0;
  int cyc = 0, lastTickCyc = 0, tickGap = 0, extCnt = 0;
  int curSample = 0;
  bit [2:0] mHist;
  int mStep, mEst;
  bit mPhase;

  always @(posedge clk) cyc <= cyc + 1;

  // External encoder bit clock: period 10, high 4
  always @(negedge clk) begin
    extCnt    <= (extCnt == 9) ? 0 : extCnt + 1;
    encExtClk <= (extCnt < 4);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mHist = '0; mStep = SMIN; mEst = 0; mPhase = 1'b0;
  endtask

  task automatic modelBit(input bit b);
    bit run3, runHit;
    run3   = (mHist[1:0] == {b, b});
    runHit = algo3 ? run3 : (run3 && mHist[2] == b);
    if (runHit) mStep = (mStep + SINC > SMAX) ? SMAX : mStep + SINC;
    else        mStep = (mStep - (mStep >>> SLEAK) < SMIN) ? SMIN : mStep - (mStep >>> SLEAK);
    mEst = mEst - (mEst >>> ELEAK);
    mEst = b ? mEst + mStep : mEst - mStep;
    if (mEst > EMAX) mEst = EMAX;
    if (mEst < EMIN) mEst = EMIN;
    mHist = {mHist[1:0], b};
  endtask

  task automatic setSample(input int v);
    @(negedge clk);
    sampleIn = W'(v); sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0; curSample = v;
  endtask

  // One encoder bit period with checks; decoder compared when cmpDec
  task automatic bitPeriod(input bit cmpDec);
    bit eb;
    string tag;
    do @(negedge clk); while (!encTick);
    tickGap = cyc - lastTickCyc;
    lastTickCyc = cyc;
    if (!encIdleN) begin eb = mPhase; mPhase = ~mPhase; tag = "R6 idle bit"; end
    else begin mPhase = 1'b0; eb = (curSample >= mEst); tag = "R2 encoder bit"; end
    modelBit(eb);
    @(negedge clk);
    check(encBit == eb, tag, encBit, eb);
    check(encEst == mEst, "R3/R4 estimate", encEst, mEst);
    repeat (3) @(negedge clk);
    if (cmpDec) check(decSample == encEst, "R8 loopback", decSample, encEst);
    check(encEst == mEst, "R12 hold between ticks", encEst, mEst);
  endtask

  initial begin
    #(5ns * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int seen;
    rstN = 0; pwrOn = 1; algo3 = 1; dataEn = 1; encClkInt = 1; decClkInt = 0;
    sampleIn = '0; sampleStb = 0; encIdleN = 1; decIdleN = 1;
    repeat (4) @(negedge clk);
    rstN = 1;
    modelReset();
    @(negedge clk);
    check(encEst == 0, "R1 reset encEst", encEst, 0);
    check(decSample == 0, "R1 reset decSample", decSample, 0);
    check(encBit == 0, "R1 reset encBit", encBit, 0);
    check(encBitEn == 1, "R9 enable after reset", encBitEn, 1);

    // Vector table: samples and run-length selection
    for (int v = 0; v < VEC_N; v++) begin
      algo3 = vecAlgo[v];
      setSample(vecSample[v]);
      for (int k = 0; k < VEC_BITS; k++) bitPeriod(1);
    end
    check(tickGap == DIV, "R10 internal tick spacing", tickGap, DIV);

    // Encoder idle force
    encIdleN = 0;
    setSample(20000);
    for (int k = 0; k < 8; k++) bitPeriod(1);
    encIdleN = 1;

    // Output enable
    @(negedge clk); dataEn = 0;
    @(negedge clk);
    check(encBitEn == 0, "R9 dataEn low", encBitEn, 0);
    for (int k = 0; k < 3; k++) bitPeriod(1);
    dataEn = 1;
    @(negedge clk);
    check(encBitEn == 1, "R9 dataEn high", encBitEn, 1);

    // Positive saturation
    algo3 = 1;
    setSample(EMAX);
    for (int k = 0; k < 120; k++) bitPeriod(1);
    check(encEst == EMAX, "R5 positive limit", encEst, EMAX);
    setSample(EMIN);
    for (int k = 0; k < 60; k++) bitPeriod(1);

    // External encoder clock
    encClkInt = 0;
    setSample(-3000);
    for (int k = 0; k < 8; k++) bitPeriod(1);
    check(tickGap == 10, "R11 external tick spacing", tickGap, 10);

    // Decoder idle force
    decIdleN = 0;
    for (int k = 0; k < 600; k++) bitPeriod(0);
    check(decSample <= 8 * SMIN && decSample >= -8 * SMIN, "R7 decoder idle settle",
          decSample, 0);

    // Power-save
    @(negedge clk); pwrOn = 0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (encTick || decTick) seen++;
    end
    check(seen == 0, "R1 no ticks in power-save", seen, 0);
    check(encEst == 0, "R1 power-save encEst", encEst, 0);
    check(decSample == 0, "R1 power-save decSample", decSample, 0);
    check(encBit == 0, "R1 power-save encBit", encBit, 0);
    check(encBitEn == 0, "R9 power-save enable", encBitEn, 0);
    decIdleN = 1; algo3 = 0;
    pwrOn = 1;
    modelReset();
    setSample(-5000);
    for (int k = 0; k < 12; k++) bitPeriod(1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule